// File: doc/BRIEF.md
# Pointer-Driven Mode Command Sequencer

This block plays back a programmed sequence of per-crossing command words, one word for each beam crossing. A list of 32-bit instructions sits in an instruction memory. Each instruction names one of 256 command groups and says how many times to replay it. A group is 120 consecutive words in a command memory, and each word is used for one crossing. After the last pass of a group the block moves to the next instruction. An instruction can also send the sequence back to the first entry, so a finite list can run forever.

Running is started by an arm sequence. A global start pulse, accepted only while start is enabled, puts the block in a waiting state. A fiducial pulse then arms it, and the next beam-clock tick begins output. Stops come from a local stop pulse or an enabled global stop pulse. A stop can take effect at once, at the end of the current instruction, or after the next instruction that carries the loop-back flag. Both memories are external and have a one-clock synchronous read. While the block runs, it gates off their write strobes. `bc_tick` is a single-clock strobe for each beam crossing, and successive strobes are at least three clocks apart.

Top module: `mode_sequencer`

## Requirements
- R1: An instruction word carries the loop-back flag in bit 31, the repeat count in bits 30..8 and the group number in bits 7..0. `cmd_addr` is {group, crossing index}, with the index in the low 7 bits.
- R2: While running, each `bc_tick` presents the command word at the current `cmd_addr` on the byte outputs after that clock edge: bits 7..0 on `mode_byte`, 15..8 on `trig_byte`, 23..16 on `pulse_byte` and 31..24 on `spare_byte`. The crossing index then advances from 0 to 119 and wraps to 0.
- R3: A group is replayed as many times as the repeat count says, and a count of 0 gives a single pass. After the final pass `ins_addr` advances by one.
- R4: When an instruction with the loop-back flag finishes, `ins_addr` returns to 0.
- R5: `glb_start` moves an idle block to waiting (`waiting`=1) only when `start_en` is 1. Otherwise it is ignored.
- R6: In the waiting state, `fid` arms the block. A `fid` pulse while idle is ignored, and so is a `bc_tick` while waiting. The first `bc_tick` after arming sets `run` and `mode_en` and presents the word at crossing index 0.
- R7: A stop is requested by `loc_stop`, or by `glb_stop` when `stop_en` is 1. `glb_stop` with `stop_en` at 0 has no effect. A stop request while waiting or armed returns the block to idle.
- R8: If `stop_eocc` is set, a requested stop ends the run at the first tick after the current instruction completes. If only `stop_eosf` is set, the run ends at the first tick after an instruction with the loop-back flag completes. If neither is set, the run ends at the next tick and nothing more is presented.
- R9: While not running, `ptr_clr` sets `ins_addr` and the crossing index to 0 and restarts the pass count. While running it is ignored.
- R10: `ins_we` and `cmd_we` follow `ins_wr_req` and `cmd_wr_req` while not running, and are 0 while running.
- R11: While not running, `run`, `mode_en` and all byte outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bc_tick | input | 1 | One-clock strobe per beam crossing |
| fid | input | 1 | Fiducial pulse |
| glb_start | input | 1 | Global start pulse |
| glb_stop | input | 1 | Global stop pulse |
| start_en | input | 1 | Accept global start |
| stop_en | input | 1 | Accept global stop |
| loc_stop | input | 1 | Local stop pulse |
| stop_eocc | input | 1 | Stop at end of current instruction |
| stop_eosf | input | 1 | Stop after a loop-back instruction |
| ptr_clr | input | 1 | Reset instruction pointer (idle only) |
| ins_addr | output | 15 | Instruction memory read address / current instruction pointer |
| ins_rdata | input | 32 | Instruction memory read data, one clock after address |
| cmd_addr | output | 15 | Command memory read address / current command pointer |
| cmd_rdata | input | 32 | Command memory read data, one clock after address |
| ins_wr_req | input | 1 | Instruction memory write request from the bus side |
| ins_we | output | 1 | Gated instruction memory write strobe |
| cmd_wr_req | input | 1 | Command memory write request from the bus side |
| cmd_we | output | 1 | Gated command memory write strobe |
| mode_byte | output | 8 | Mode byte for the current crossing |
| trig_byte | output | 8 | Local trigger byte |
| pulse_byte | output | 8 | Pulse generator byte |
| spare_byte | output | 8 | Upper byte of the command word |
| mode_en | output | 1 | High while mode bytes are valid |
| run | output | 1 | Running status |
| waiting | output | 1 | Waiting for fiducial |

## Verification
If the crossing index or the group is wrong, the mode and trigger bytes are wrong at the very next tick. The test command memory encodes the index and the group in the word itself, so every crossing is compared directly. A wrong pass count or next-pointer choice shows on `ins_addr` at the tick that ends an instruction, and on the group byte one tick later. A wrong stop decision shows as `run` falling one instruction early or late, and the bench checks `run` at both the last presented crossing and the following tick.

// File: rtl/mode_sequencer.sv
module mode_sequencer #(
  parameter int XINGS   = 120,
  parameter int IDX_W   = 7,
  parameter int GRP_W   = 8,
  parameter int IADDR_W = 15,
  parameter int RPT_W   = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bc_tick,
  input  logic                     fid,
  input  logic                     glb_start,
  input  logic                     glb_stop,
  input  logic                     start_en,
  input  logic                     stop_en,
  input  logic                     loc_stop,
  input  logic                     stop_eocc,
  input  logic                     stop_eosf,
  input  logic                     ptr_clr,
  output logic [IADDR_W-1:0]       ins_addr,
  input  logic [31:0]              ins_rdata,
  output logic [GRP_W+IDX_W-1:0]   cmd_addr,
  input  logic [31:0]              cmd_rdata,
  input  logic                     ins_wr_req,
  output logic                     ins_we,
  input  logic                     cmd_wr_req,
  output logic                     cmd_we,
  output logic [7:0]               mode_byte,
  output logic [7:0]               trig_byte,
  output logic [7:0]               pulse_byte,
  output logic [7:0]               spare_byte,
  output logic                     mode_en,
  output logic                     run,
  output logic                     waiting
);
  localparam int LAST   = XINGS - 1;
  localparam int LOOP_B = 31;
  localparam int RPT_LO = GRP_W;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ARMED, S_RUN} st_t;

  st_t                st;
  logic [IADDR_W-1:0] iptr;
  logic [IDX_W-1:0]   idx;
  logic [RPT_W-1:0]   passes;
  logic               stop_pend, halt_q;

  wire              loop_f  = ins_rdata[LOOP_B];
  wire [RPT_W-1:0]  rpt     = ins_rdata[RPT_LO +: RPT_W];
  wire [GRP_W-1:0]  grp     = ins_rdata[GRP_W-1:0];

  wire stop_req  = loc_stop | (glb_stop & stop_en);
  wire stop_any  = stop_req | stop_pend;
  wire imm_stop  = stop_any & ~stop_eocc & ~stop_eosf;
  wire end_grp   = (idx == IDX_W'(LAST));
  wire last_pass = ({1'b0, passes} + 1'b1) >= {1'b0, rpt};
  wire end_ins   = end_grp & last_pass;
  wire quit_set  = end_ins & stop_any & (stop_eocc | (stop_eosf & loop_f));

  wire step = bc_tick & (((st == S_ARMED) & ~stop_req) |
                         ((st == S_RUN) & ~halt_q & ~imm_stop));
  wire go_idle = (((st == S_WAIT) | (st == S_ARMED)) & stop_req) |
                 ((st == S_RUN) & bc_tick & (halt_q | imm_stop));

  assign ins_addr = iptr;
  assign cmd_addr = {grp, idx};
  assign run      = (st == S_RUN);
  assign mode_en  = run;
  assign waiting  = (st == S_WAIT);
  assign ins_we   = ins_wr_req & ~run;
  assign cmd_we   = cmd_wr_req & ~run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      iptr       <= '0;
      idx        <= '0;
      passes     <= '0;
      stop_pend  <= 1'b0;
      halt_q     <= 1'b0;
      mode_byte  <= '0;
      trig_byte  <= '0;
      pulse_byte <= '0;
      spare_byte <= '0;
    end else if (go_idle) begin
      st         <= S_IDLE;
      stop_pend  <= 1'b0;
      halt_q     <= 1'b0;
      mode_byte  <= '0;
      trig_byte  <= '0;
      pulse_byte <= '0;
      spare_byte <= '0;
    end else begin
      if (st == S_RUN && stop_req) stop_pend <= 1'b1;
      if (st == S_IDLE && glb_start && start_en) st <= S_WAIT;
      if (st == S_WAIT && fid) st <= S_ARMED;
      if (st == S_IDLE && ptr_clr) begin
        iptr   <= '0;
        idx    <= '0;
        passes <= '0;
      end
      if (step) begin
        mode_byte  <= cmd_rdata[7:0];
        trig_byte  <= cmd_rdata[15:8];
        pulse_byte <= cmd_rdata[23:16];
        spare_byte <= cmd_rdata[31:24];
        if (st == S_ARMED) st <= S_RUN;
        if (quit_set) halt_q <= 1'b1;
        if (end_grp) begin
          idx <= '0;
          if (last_pass) begin
            passes <= '0;
            iptr   <= loop_f ? '0 : iptr + 1'b1;
          end else begin
            passes <= passes + 1'b1;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(LAST));

  a_r6_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(st == S_ARMED && bc_tick));

  a_r5_wait_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting) |-> $past(glb_start && start_en));

  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bc_tick && !ptr_clr) |=> $stable(ins_addr));

  a_r4_loop_back: assert property (@(posedge clk) disable iff (!rst_n)
    (step && end_ins && loop_f) |=> (ins_addr == '0));

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (mode_byte == 8'd0 && trig_byte == 8'd0 && pulse_byte == 8'd0 && spare_byte == 8'd0));

  a_r10_we_gate: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (!ins_we && !cmd_we));
endmodule

// File: tb/tb_mode_sequencer.sv
module tb_mode_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bc_tick = 0, fid = 0, glb_start = 0, glb_stop = 0, start_en = 0, stop_en = 0;
  logic loc_stop = 0, stop_eocc = 0, stop_eosf = 0, ptr_clr = 0;
  logic ins_wr_req = 0, cmd_wr_req = 0;
  logic [14:0] ins_addr, cmd_addr;
  logic [31:0] ins_rdata = '0, cmd_rdata = '0;
  logic ins_we, cmd_we, mode_en, run, waiting;
  logic [7:0] mode_byte, trig_byte, pulse_byte, spare_byte;

  logic [31:0] ins_mem [0:7];
  int n_chk = 0, n_fail = 0;
  int exp_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_sequencer dut (
    .clk(clk), .rst_n(rst_n), .bc_tick(bc_tick), .fid(fid),
    .glb_start(glb_start), .glb_stop(glb_stop), .start_en(start_en), .stop_en(stop_en),
    .loc_stop(loc_stop), .stop_eocc(stop_eocc), .stop_eosf(stop_eosf), .ptr_clr(ptr_clr),
    .ins_addr(ins_addr), .ins_rdata(ins_rdata), .cmd_addr(cmd_addr), .cmd_rdata(cmd_rdata),
    .ins_wr_req(ins_wr_req), .ins_we(ins_we), .cmd_wr_req(cmd_wr_req), .cmd_we(cmd_we),
    .mode_byte(mode_byte), .trig_byte(trig_byte), .pulse_byte(pulse_byte),
    .spare_byte(spare_byte), .mode_en(mode_en), .run(run), .waiting(waiting)
  );

  function automatic logic [31:0] cmd_fn(input logic [14:0] a);
    return {8'hC3, ~a[14:7], a[14:7], 1'b0, a[6:0]};
  endfunction

  always @(posedge clk) begin
    ins_rdata <= ins_mem[ins_addr[2:0]];
    cmd_rdata <= cmd_fn(cmd_addr);
  end

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bc_tick = 1'b1;
    @(negedge clk) bc_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xing(input logic [7:0] g, input string tag);
    tick();
    check(tag, {run, spare_byte, pulse_byte, trig_byte, mode_byte},
          {1'b1, 8'hC3, ~g, g, 1'b0, 7'(exp_idx)});
    exp_idx = (exp_idx == 119) ? 0 : exp_idx + 1;
  endtask

  task automatic xings(input logic [7:0] g, input int n, input string tag);
    for (int i = 0; i < n; i++) xing(g, tag);
  endtask

  task automatic start_run();
    @(negedge clk) glb_start = 1'b1;
    @(negedge clk) glb_start = 1'b0;
    @(negedge clk) fid = 1'b1;
    @(negedge clk) fid = 1'b0;
  endtask

  task automatic pulse_loc_stop();
    @(negedge clk) loc_stop = 1'b1;
    @(negedge clk) loc_stop = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) ptr_clr = 1'b1;
    @(negedge clk) ptr_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 reset state", {run, mode_en, waiting, mode_byte, trig_byte}, '0);
    check("R9 reset pointer", ins_addr, '0);
  endtask

  task automatic t_gating_idle();
    start_en = 1'b0;
    @(negedge clk) glb_start = 1'b1;
    @(negedge clk) glb_start = 1'b0;
    check("R5 start ignored without enable", waiting, 0);
    @(negedge clk) fid = 1'b1;
    @(negedge clk) fid = 1'b0;
    tick();
    check("R6 fid while idle ignored", {run, waiting}, 0);
    @(negedge clk) begin ins_wr_req = 1'b1; cmd_wr_req = 1'b1; end
    @(negedge clk);
    check("R10 writes pass when stopped", {ins_we, cmd_we}, 2'b11);
    ins_wr_req = 1'b0; cmd_wr_req = 1'b0;
  endtask

  task automatic t_arm_and_loop();
    start_en = 1'b1;
    @(negedge clk) glb_start = 1'b1;
    @(negedge clk) glb_start = 1'b0;
    check("R5 waiting after enabled start", waiting, 1);
    tick();
    check("R6 tick while waiting ignored", {run, waiting}, 2'b01);
    @(negedge clk) fid = 1'b1;
    @(negedge clk) fid = 1'b0;
    check("R6 armed, not yet running", {run, waiting}, 0);
    exp_idx = 0;
    xing(8'd5, "R6 first word at index 0");
    check("R6 mode_en with run", mode_en, 1);
    check("R1 command address = {group,index}", cmd_addr, {8'd5, 7'd1});
    @(negedge clk) begin ins_wr_req = 1'b1; cmd_wr_req = 1'b1; end
    @(negedge clk);
    check("R10 writes blocked while running", {ins_we, cmd_we}, 2'b00);
    ins_wr_req = 1'b0; cmd_wr_req = 1'b0;
    stop_en = 1'b0;
    @(negedge clk) glb_stop = 1'b1;
    @(negedge clk) glb_stop = 1'b0;
    xings(8'd5, 119 + 120, "R2 group 5 playback");
    check("R3 pointer advances after two passes", ins_addr, 15'd1);
    xing(8'd9, "R2 group 9 playback");
    pulse_clr();
    check("R9 pointer clear ignored while running", ins_addr, 15'd1);
    xings(8'd9, 119, "R2 group 9 playback");
    check("R3 zero repeat gives single pass", ins_addr, 15'd2);
    xings(8'd3, 120, "R2 group 3 playback");
    check("R4 loop-back to entry 0", ins_addr, 15'd0);
    check("R7 disabled global stop ignored", run, 1);
  endtask

  task automatic t_stop_eocc();
    stop_eocc = 1'b1;
    xings(8'd5, 10, "R8 run before local stop");
    pulse_loc_stop();
    xings(8'd5, 110 + 120, "R8 runs to end of instruction");
    tick();
    check("R8 stop after current instruction", {run, mode_en, mode_byte}, '0);
    check("R8 pointer at next instruction", ins_addr, 15'd1);
    stop_eocc = 1'b0;
    pulse_clr();
    check("R9 pointer clear while stopped", ins_addr, 15'd0);
  endtask

  task automatic t_stop_now();
    start_run();
    exp_idx = 0;
    xings(8'd5, 5, "R6 restart from entry 0");
    pulse_loc_stop();
    tick();
    check("R8 immediate stop, R11 outputs quiet", {run, mode_byte, trig_byte}, '0);
    check("R8 index held at stop", cmd_addr, {8'd5, 7'd5});
    pulse_clr();
    check("R9 clear restarts crossing index", cmd_addr, {8'd5, 7'd0});
    @(negedge clk) glb_start = 1'b1;
    @(negedge clk) glb_start = 1'b0;
    check("R5 waiting again", waiting, 1);
    pulse_loc_stop();
    check("R7 stop while waiting returns idle", {waiting, run}, 0);
  endtask

  task automatic t_stop_eosf();
    stop_eosf = 1'b1;
    stop_en = 1'b1;
    start_run();
    exp_idx = 0;
    xings(8'd5, 3, "R8 sequence run");
    @(negedge clk) glb_stop = 1'b1;
    @(negedge clk) glb_stop = 1'b0;
    xings(8'd5, 237, "R8 sequence run");
    check("R8 no stop at non-loop instruction end", {run, ins_addr}, {1'b1, 15'd1});
    xings(8'd9, 120, "R8 sequence run");
    xings(8'd3, 120, "R8 sequence run");
    check("R7 enabled global stop pending, still running", run, 1);
    tick();
    check("R8 stop after loop-back instruction", {run, ins_addr}, {1'b0, 15'd0});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) ins_mem[i] = '0;
    ins_mem[0] = {1'b0, 23'd2, 8'd5};
    ins_mem[1] = {1'b0, 23'd0, 8'd9};
    ins_mem[2] = {1'b1, 23'd1, 8'd3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating_idle();
    t_arm_and_loop();
    t_stop_eocc();
    t_stop_now();
    t_stop_eosf();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule